// File: doc/BRIEF.md
# Synchronous Dual-Port Burst SRAM

This block is a true dual-port synchronous memory with two fully independent ports, left and right. Each port runs on its own clock and reset. Either port can read or write any word, and both ports may address the same word at the same time. Every port keeps its address in a registered counter. That counter can be cleared, loaded from the external address pins, or stepped by one, so a burst of consecutive words moves without fresh addresses.

The data word holds two byte lanes. Lane 1 is the upper byte, bits `[2*BYTE_W-1:BYTE_W]`, and lane 0 is the lower byte, bits `[BYTE_W-1:0]`. `BYTE_W` is 8 by default, giving a 16-bit word, and 9 gives an 18-bit word. `ADDR_W` sets the depth to 2^ADDR_W words. It defaults to 10 so the model stays small, and it is set to 15 or 16 for 32K or 64K words.

A port is selected when its active-high enable is 1 and its active-low enable is 0. A static mode input on each port picks the read path. In flow-through mode the word comes straight from the array behind the address register. In pipelined mode one more register follows, clocked one edge later. The bus direction is modelled with separate data in and data out pins. A per-lane valid flag stands in for a high-impedance output.

Top module: `dual_port_burst_ram`

## Requirements
- R1: The counter clear input (`*_cnt_clear_n` = 0) sets the port address to 0 at the clock edge and overrides load and step.
- R2: The load input (`*_adr_load_n` = 0, with clear inactive) copies `*_addr` into the port address and overrides step.
- R3: The step input (`*_cnt_step_n` = 0, with clear and load inactive) adds one to the port address, and the address wraps from 2^ADDR_W-1 to 0.
- R4: With clear, load and step all at 1, the port address holds its value.
- R5: A write happens at a clock edge when the port is selected, `*_wr_n` = 0 and at least one byte enable is 0 (`*_hi_byte_n` for lane 1, `*_lo_byte_n` for lane 0). The word written is the one the port address takes at that edge, and only the enabled lanes change.
- R6: A port whose `*_cs_hi` is 0 or whose `*_cs_lo_n` is 1 neither writes nor returns read data.
- R7: With `*_pipe_mode` = 0, read data for an edge at which the port was selected with `*_wr_n` = 1 appears on the port shortly after that same edge.
- R8: With `*_pipe_mode` = 1, read data appears one port-clock edge later than in flow-through mode.
- R9: While `*_out_en_n` = 1, the `*_dout_vld` flags are 0 and `*_dout` is 0. Output enable acts without waiting for a clock edge.
- R10: On a read, only the lanes whose byte enable was 0 at the addressing edge are flagged valid. Non-valid lanes of `*_dout` read 0.
- R11: A word written through one port reads back through the other, lane by lane. The most recent write to a lane wins, whichever port made it.
- R12: After reset, both ports' valid flags are 0 and both port addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port asynchronous reset, active low |
| l_addr | input | ADDR_W | Left external address |
| l_adr_load_n | input | 1 | Left counter load, active low |
| l_cnt_step_n | input | 1 | Left counter increment, active low |
| l_cnt_clear_n | input | 1 | Left counter clear, active low |
| l_cs_hi | input | 1 | Left chip enable, active high |
| l_cs_lo_n | input | 1 | Left chip enable, active low |
| l_wr_n | input | 1 | Left write (0) / read (1) |
| l_hi_byte_n | input | 1 | Left upper lane enable, active low |
| l_lo_byte_n | input | 1 | Left lower lane enable, active low |
| l_out_en_n | input | 1 | Left output enable, active low |
| l_pipe_mode | input | 1 | Left read path: 0 flow-through, 1 pipelined |
| l_din | input | 2*BYTE_W | Left write data |
| l_dout | output | 2*BYTE_W | Left read data |
| l_dout_vld | output | 2 | Left per-lane valid (bit 1 upper) |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port asynchronous reset, active low |
| r_addr | input | ADDR_W | Right external address |
| r_adr_load_n | input | 1 | Right counter load, active low |
| r_cnt_step_n | input | 1 | Right counter increment, active low |
| r_cnt_clear_n | input | 1 | Right counter clear, active low |
| r_cs_hi | input | 1 | Right chip enable, active high |
| r_cs_lo_n | input | 1 | Right chip enable, active low |
| r_wr_n | input | 1 | Right write (0) / read (1) |
| r_hi_byte_n | input | 1 | Right upper lane enable, active low |
| r_lo_byte_n | input | 1 | Right lower lane enable, active low |
| r_out_en_n | input | 1 | Right output enable, active low |
| r_pipe_mode | input | 1 | Right read path: 0 flow-through, 1 pipelined |
| r_din | input | 2*BYTE_W | Right write data |
| r_dout | output | 2*BYTE_W | Right read data |
| r_dout_vld | output | 2 | Right per-lane valid (bit 1 upper) |

## Verification
A corrupted port address shows up as the wrong word, or as a misplaced write. In flow-through mode it becomes visible in the same cycle as the first read after the fault, and in pipelined mode one edge later. A counter sweep across every word, including the wrap, therefore localises any counter slip to a single step. A wrong lane ownership tag in the shared array shows as a stale byte at the opposite port on its next read of that word. Mixed-lane writes from both ports, read back per lane, expose it within one access. A pipeline register that is stuck or bypassed shifts every word of a pipelined burst by one position, so the first word of that burst already differs.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        CTR_HOLD  = 2'd0,
        CTR_STEP  = 2'd1,
        CTR_LOAD  = 2'd2,
        CTR_CLEAR = 2'd3
    } ctr_act_e;
endpackage

// File: rtl/dpbr_port_front.sv
module dpbr_port_front
    import dpbr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              adr_load_n,
    input  logic              cnt_step_n,
    input  logic              cnt_clear_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_en_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  rd_lanes_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  rd_lanes;
    } front_t;

    front_t   front_d, front_q;
    ctr_act_e act;
    logic     selected;

    always_comb begin
        selected = cs_hi & ~cs_lo_n;
        if (!cnt_clear_n)      act = CTR_CLEAR;
        else if (!adr_load_n)  act = CTR_LOAD;
        else if (!cnt_step_n)  act = CTR_STEP;
        else                   act = CTR_HOLD;

        front_d = front_q;
        unique case (act)
            CTR_CLEAR: front_d.addr = '0;
            CTR_LOAD:  front_d.addr = addr_in;
            CTR_STEP:  front_d.addr = front_q.addr + ADDR_W'(1);
            default:   front_d.addr = front_q.addr;
        endcase
        front_d.rd_lanes = (selected && wr_n) ? ~lane_en_n : '0;

        wr_lanes = ~lane_en_n;
        wr_en    = selected & ~wr_n & (|wr_lanes);
        wr_addr  = front_d.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) front_q <= '0;
        else        front_q <= front_d;
    end

    assign addr_q     = front_q.addr;
    assign rd_lanes_q = front_q.rd_lanes;

    // R1
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear_n |=> (addr_q == '0));
    // R2
    load_over_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clear_n && !adr_load_n) |=> (addr_q == $past(addr_in)));
    // R3
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clear_n && adr_load_n && !cnt_step_n) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
    // R4
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clear_n && adr_load_n && cnt_step_n) |=> $stable(addr_q));
    // R6
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_hi || cs_lo_n) |=> (rd_lanes_q == '0));
endmodule

// File: rtl/dpbr_bank.sv
module dpbr_bank
    import dpbr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] wa_a,
    input  logic [LANES-1:0]  wl_a,
    input  logic [LANES*BYTE_W-1:0] wd_a,
    input  logic [ADDR_W-1:0] ra_a,
    output logic [LANES*BYTE_W-1:0] rd_a,
    input  logic              clk_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] wa_b,
    input  logic [LANES-1:0]  wl_b,
    input  logic [LANES*BYTE_W-1:0] wd_b,
    input  logic [ADDR_W-1:0] ra_b,
    output logic [LANES*BYTE_W-1:0] rd_b
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * BYTE_W;

    // Each port owns one data copy and one tag per lane; a lane belongs to
    // side A when the tags differ and to side B when they match.
    logic [DATA_W-1:0] mem_a [DEPTH];
    logic [DATA_W-1:0] mem_b [DEPTH];
    logic [LANES-1:0]  tag_a [DEPTH];
    logic [LANES-1:0]  tag_b [DEPTH];

    always_ff @(posedge clk_a) begin
        if (we_a) begin
            for (int l = 0; l < LANES; l++) begin
                if (wl_a[l]) begin
                    mem_a[wa_a][l*BYTE_W +: BYTE_W] <= wd_a[l*BYTE_W +: BYTE_W];
                    tag_a[wa_a][l] <= ~tag_b[wa_a][l];
                end
            end
        end
    end

    always_ff @(posedge clk_b) begin
        if (we_b) begin
            for (int l = 0; l < LANES; l++) begin
                if (wl_b[l]) begin
                    mem_b[wa_b][l*BYTE_W +: BYTE_W] <= wd_b[l*BYTE_W +: BYTE_W];
                    tag_b[wa_b][l] <= tag_a[wa_b][l];
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_a[l*BYTE_W +: BYTE_W] = (tag_a[ra_a][l] ^ tag_b[ra_a][l])
                ? mem_a[ra_a][l*BYTE_W +: BYTE_W] : mem_b[ra_a][l*BYTE_W +: BYTE_W];
            rd_b[l*BYTE_W +: BYTE_W] = (tag_a[ra_b][l] ^ tag_b[ra_b][l])
                ? mem_a[ra_b][l*BYTE_W +: BYTE_W] : mem_b[ra_b][l*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/dpbr_rd_out.sv
module dpbr_rd_out
    import dpbr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    out_en_n,
    input  logic [LANES-1:0]        rd_lanes_q,
    input  logic [LANES*BYTE_W-1:0] arr_word,
    output logic [LANES*BYTE_W-1:0] dout,
    output logic [LANES-1:0]        dout_vld
);
    localparam int DATA_W = LANES * BYTE_W;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [LANES-1:0]  lanes;
    } pipe_t;

    pipe_t             pipe_d, pipe_q;
    logic [DATA_W-1:0] word_sel;
    logic [LANES-1:0]  lanes_sel;

    always_comb begin
        pipe_d.word  = arr_word;
        pipe_d.lanes = rd_lanes_q;
        word_sel  = pipe_mode ? pipe_q.word  : arr_word;
        lanes_sel = pipe_mode ? pipe_q.lanes : rd_lanes_q;
        dout_vld  = out_en_n ? '0 : lanes_sel;
        for (int l = 0; l < LANES; l++) begin
            dout[l*BYTE_W +: BYTE_W] = dout_vld[l] ? word_sel[l*BYTE_W +: BYTE_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // R9
    oe_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (dout_vld == '0 && dout == '0));
    // R8
    pipe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !out_en_n) |-> (dout_vld == $past(rd_lanes_q)));
endmodule

// File: rtl/dual_port_burst_ram.sv
module dual_port_burst_ram
    import dpbr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic                    l_clk,
    input  logic                    l_rst_n,
    input  logic [ADDR_W-1:0]       l_addr,
    input  logic                    l_adr_load_n,
    input  logic                    l_cnt_step_n,
    input  logic                    l_cnt_clear_n,
    input  logic                    l_cs_hi,
    input  logic                    l_cs_lo_n,
    input  logic                    l_wr_n,
    input  logic                    l_hi_byte_n,
    input  logic                    l_lo_byte_n,
    input  logic                    l_out_en_n,
    input  logic                    l_pipe_mode,
    input  logic [2*BYTE_W-1:0]     l_din,
    output logic [2*BYTE_W-1:0]     l_dout,
    output logic [1:0]              l_dout_vld,
    input  logic                    r_clk,
    input  logic                    r_rst_n,
    input  logic [ADDR_W-1:0]       r_addr,
    input  logic                    r_adr_load_n,
    input  logic                    r_cnt_step_n,
    input  logic                    r_cnt_clear_n,
    input  logic                    r_cs_hi,
    input  logic                    r_cs_lo_n,
    input  logic                    r_wr_n,
    input  logic                    r_hi_byte_n,
    input  logic                    r_lo_byte_n,
    input  logic                    r_out_en_n,
    input  logic                    r_pipe_mode,
    input  logic [2*BYTE_W-1:0]     r_din,
    output logic [2*BYTE_W-1:0]     r_dout,
    output logic [1:0]              r_dout_vld
);
    localparam int DATA_W = LANES * BYTE_W;
    localparam int NPORT  = 2;

    logic              p_clk      [NPORT];
    logic              p_rst_n    [NPORT];
    logic [ADDR_W-1:0] p_addr     [NPORT];
    logic              p_load_n   [NPORT];
    logic              p_step_n   [NPORT];
    logic              p_clear_n  [NPORT];
    logic              p_cs_hi    [NPORT];
    logic              p_cs_lo_n  [NPORT];
    logic              p_wr_n     [NPORT];
    logic [LANES-1:0]  p_lane_n   [NPORT];
    logic              p_oe_n     [NPORT];
    logic              p_pipe     [NPORT];
    logic [DATA_W-1:0] p_din      [NPORT];
    logic [DATA_W-1:0] p_dout     [NPORT];
    logic [LANES-1:0]  p_vld      [NPORT];
    logic              p_we       [NPORT];
    logic [ADDR_W-1:0] p_wa       [NPORT];
    logic [LANES-1:0]  p_wl       [NPORT];
    logic [ADDR_W-1:0] p_ra       [NPORT];
    logic [LANES-1:0]  p_rlanes   [NPORT];
    logic [DATA_W-1:0] p_arr      [NPORT];

    assign p_clk[0] = l_clk;          assign p_clk[1] = r_clk;
    assign p_rst_n[0] = l_rst_n;      assign p_rst_n[1] = r_rst_n;
    assign p_addr[0] = l_addr;        assign p_addr[1] = r_addr;
    assign p_load_n[0] = l_adr_load_n; assign p_load_n[1] = r_adr_load_n;
    assign p_step_n[0] = l_cnt_step_n; assign p_step_n[1] = r_cnt_step_n;
    assign p_clear_n[0] = l_cnt_clear_n; assign p_clear_n[1] = r_cnt_clear_n;
    assign p_cs_hi[0] = l_cs_hi;      assign p_cs_hi[1] = r_cs_hi;
    assign p_cs_lo_n[0] = l_cs_lo_n;  assign p_cs_lo_n[1] = r_cs_lo_n;
    assign p_wr_n[0] = l_wr_n;        assign p_wr_n[1] = r_wr_n;
    assign p_lane_n[0] = {l_hi_byte_n, l_lo_byte_n};
    assign p_lane_n[1] = {r_hi_byte_n, r_lo_byte_n};
    assign p_oe_n[0] = l_out_en_n;    assign p_oe_n[1] = r_out_en_n;
    assign p_pipe[0] = l_pipe_mode;   assign p_pipe[1] = r_pipe_mode;
    assign p_din[0] = l_din;          assign p_din[1] = r_din;
    assign l_dout = p_dout[0];        assign r_dout = p_dout[1];
    assign l_dout_vld = p_vld[0];     assign r_dout_vld = p_vld[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpbr_port_front #(.ADDR_W(ADDR_W)) u_front (
            .clk        (p_clk[p]),
            .rst_n      (p_rst_n[p]),
            .addr_in    (p_addr[p]),
            .adr_load_n (p_load_n[p]),
            .cnt_step_n (p_step_n[p]),
            .cnt_clear_n(p_clear_n[p]),
            .cs_hi      (p_cs_hi[p]),
            .cs_lo_n    (p_cs_lo_n[p]),
            .wr_n       (p_wr_n[p]),
            .lane_en_n  (p_lane_n[p]),
            .wr_en      (p_we[p]),
            .wr_addr    (p_wa[p]),
            .wr_lanes   (p_wl[p]),
            .addr_q     (p_ra[p]),
            .rd_lanes_q (p_rlanes[p])
        );

        dpbr_rd_out #(.BYTE_W(BYTE_W)) u_rd (
            .clk       (p_clk[p]),
            .rst_n     (p_rst_n[p]),
            .pipe_mode (p_pipe[p]),
            .out_en_n  (p_oe_n[p]),
            .rd_lanes_q(p_rlanes[p]),
            .arr_word  (p_arr[p]),
            .dout      (p_dout[p]),
            .dout_vld  (p_vld[p])
        );
    end

    dpbr_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_bank (
        .clk_a(p_clk[0]), .we_a(p_we[0]), .wa_a(p_wa[0]), .wl_a(p_wl[0]),
        .wd_a(p_din[0]), .ra_a(p_ra[0]), .rd_a(p_arr[0]),
        .clk_b(p_clk[1]), .we_b(p_we[1]), .wa_b(p_wa[1]), .wl_b(p_wl[1]),
        .wd_b(p_din[1]), .ra_b(p_ra[1]), .rd_b(p_arr[1])
    );
endmodule

// File: tb/sim_dual_port_burst_ram.sv
`timescale 1ns/1ps
module sim_dual_port_burst_ram;
    localparam int AW = 4;
    localparam int BW = 9;
    localparam int DW = 2 * BW;
    localparam int NW = 1 << AW;

    logic clk_l = 1'b0;
    logic clk_r = 1'b0;
    logic rst_n;
    logic [AW-1:0] a    [2];
    logic          ld_n [2];
    logic          st_n [2];
    logic          cl_n [2];
    logic          ch   [2];
    logic          cln  [2];
    logic          wn   [2];
    logic          hb   [2];
    logic          lb   [2];
    logic          oe   [2];
    logic          pm   [2];
    logic [DW-1:0] di   [2];
    logic [DW-1:0] dq   [2];
    logic [1:0]    dv   [2];

    logic [DW-1:0] model [NW];
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk_l = ~clk_l;
    initial begin
        #3;
        forever #5 clk_r = ~clk_r;
    end

    dual_port_burst_ram #(.ADDR_W(AW), .BYTE_W(BW)) u0 (
        .l_clk(clk_l), .l_rst_n(rst_n), .l_addr(a[0]), .l_adr_load_n(ld_n[0]),
        .l_cnt_step_n(st_n[0]), .l_cnt_clear_n(cl_n[0]), .l_cs_hi(ch[0]),
        .l_cs_lo_n(cln[0]), .l_wr_n(wn[0]), .l_hi_byte_n(hb[0]), .l_lo_byte_n(lb[0]),
        .l_out_en_n(oe[0]), .l_pipe_mode(pm[0]), .l_din(di[0]), .l_dout(dq[0]),
        .l_dout_vld(dv[0]),
        .r_clk(clk_r), .r_rst_n(rst_n), .r_addr(a[1]), .r_adr_load_n(ld_n[1]),
        .r_cnt_step_n(st_n[1]), .r_cnt_clear_n(cl_n[1]), .r_cs_hi(ch[1]),
        .r_cs_lo_n(cln[1]), .r_wr_n(wn[1]), .r_hi_byte_n(hb[1]), .r_lo_byte_n(lb[1]),
        .r_out_en_n(oe[1]), .r_pipe_mode(pm[1]), .r_din(di[1]), .r_dout(dq[1]),
        .r_dout_vld(dv[1])
    );

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    task automatic chk(int p, string tag, logic [DW+1:0] act, logic [DW+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s port%0d: actual %h expected %h", tag, p, act, exp);
        end
    endtask

    function automatic logic [DW+1:0] ex(int adr, logic [1:0] l);
        logic [DW-1:0] m;
        m = {{BW{l[1]}}, {BW{l[0]}}};
        return {l, model[adr] & m};
    endfunction

    function automatic logic [DW-1:0] pat(int adr, int salt);
        return DW'(adr * 12345 + salt * 4099 + 777);
    endfunction

    function automatic logic [DW+1:0] obs(int p);
        return {dv[p], dq[p]};
    endfunction

    task automatic idle(int p);
        ch[p] = 1'b0; cln[p] = 1'b1; wn[p] = 1'b1; hb[p] = 1'b1; lb[p] = 1'b1;
        ld_n[p] = 1'b1; st_n[p] = 1'b1; cl_n[p] = 1'b1; oe[p] = 1'b0;
    endtask

    task automatic tick(int p);
        if (p == 0) @(posedge clk_l);
        else        @(posedge clk_r);
        #1;
    endtask

    task automatic wr(int p, int adr, logic [DW-1:0] d, logic [1:0] lanes);
        ch[p] = 1'b1; cln[p] = 1'b0; wn[p] = 1'b0;
        hb[p] = ~lanes[1]; lb[p] = ~lanes[0];
        ld_n[p] = 1'b0; a[p] = AW'(adr); di[p] = d;
        tick(p);
        if (lanes[1]) model[adr][DW-1:BW] = d[DW-1:BW];
        if (lanes[0]) model[adr][BW-1:0]  = d[BW-1:0];
        idle(p);
    endtask

    task automatic rd(int p, int adr, logic [1:0] lanes);
        ch[p] = 1'b1; cln[p] = 1'b0; wn[p] = 1'b1;
        hb[p] = ~lanes[1]; lb[p] = ~lanes[0];
        ld_n[p] = 1'b0; a[p] = AW'(adr);
        tick(p);
        idle(p);
    endtask

    initial begin
        rst_n = 1'b0;
        for (int p = 0; p < 2; p++) begin
            idle(p); pm[p] = 1'b0; a[p] = '0; di[p] = '0;
        end
        #32 rst_n = 1'b1;
        #1;
        // R12: valid flags clear after reset
        chk(0, "R12", obs(0), '0);
        chk(1, "R12", obs(1), '0);

        // R5/R7: fill every word from the left port, read back flow-through
        for (int i = 0; i < NW; i++) wr(0, i, pat(i, 1), 2'b11);
        for (int i = 0; i < NW; i++) begin
            rd(0, i, 2'b11);
            chk(0, "R7", obs(0), ex(i, 2'b11));
        end

        // R11/R1/R3: right port burst via clear then steps, with wrap
        ch[1] = 1'b1; cln[1] = 1'b0; hb[1] = 1'b0; lb[1] = 1'b0; cl_n[1] = 1'b0;
        tick(1);
        chk(1, "R1", obs(1), ex(0, 2'b11));
        cl_n[1] = 1'b1; st_n[1] = 1'b0;
        for (int i = 1; i <= NW; i++) begin
            tick(1);
            chk(1, "R3", obs(1), ex(i % NW, 2'b11));
        end
        idle(1);

        // R8: pipelined burst on right port lags by one edge
        pm[1] = 1'b1;
        tick(1);
        ch[1] = 1'b1; cln[1] = 1'b0; hb[1] = 1'b0; lb[1] = 1'b0; cl_n[1] = 1'b0;
        tick(1);
        chk(1, "R8", obs(1), '0);
        cl_n[1] = 1'b1; st_n[1] = 1'b0;
        for (int i = 1; i < NW; i++) begin
            tick(1);
            chk(1, "R8", obs(1), ex(i - 1, 2'b11));
        end
        idle(1);
        tick(1);
        chk(1, "R8", obs(1), ex(NW - 1, 2'b11));
        tick(1);
        chk(1, "R8", obs(1), '0);
        pm[1] = 1'b0;

        // R5: every lane mask on one word, including no lanes
        for (int m = 0; m < 4; m++) begin
            wr(0, 2, pat(2, 10 + m), 2'(m));
            rd(1, 2, 2'b11);
            chk(1, "R5", obs(1), ex(2, 2'b11));
        end

        // R10: read lane enables
        rd(1, 5, 2'b01);
        chk(1, "R10", obs(1), ex(5, 2'b01));
        rd(1, 5, 2'b10);
        chk(1, "R10", obs(1), ex(5, 2'b10));
        rd(1, 5, 2'b00);
        chk(1, "R10", obs(1), '0);

        // R9: output enable gates asynchronously
        rd(0, 1, 2'b11);
        oe[0] = 1'b1; #1;
        chk(0, "R9", obs(0), '0);
        oe[0] = 1'b0; #1;
        chk(0, "R9", obs(0), ex(1, 2'b11));

        // R6: either enable inactive blocks writes and reads
        for (int c = 0; c < 2; c++) begin
            ch[0] = (c == 1); cln[0] = (c == 1); wn[0] = 1'b0;
            hb[0] = 1'b0; lb[0] = 1'b0; ld_n[0] = 1'b0; a[0] = 4'd4;
            di[0] = ~model[4];
            tick(0);
            chk(0, "R6", obs(0), '0);
            wn[0] = 1'b1;
            tick(0);
            chk(0, "R6", obs(0), '0);
            idle(0);
            rd(1, 4, 2'b11);
            chk(1, "R6", obs(1), ex(4, 2'b11));
        end

        // R1/R2/R4: counter priority and hold, seen through read data
        rd(0, 9, 2'b11);
        chk(0, "R2", obs(0), ex(9, 2'b11));
        ch[0] = 1'b1; cln[0] = 1'b0; hb[0] = 1'b0; lb[0] = 1'b0;
        tick(0);
        chk(0, "R4", obs(0), ex(9, 2'b11));
        cl_n[0] = 1'b0; ld_n[0] = 1'b0; st_n[0] = 1'b0; a[0] = 4'd9;
        tick(0);
        chk(0, "R1", obs(0), ex(0, 2'b11));
        cl_n[0] = 1'b1; a[0] = 4'd6;
        tick(0);
        chk(0, "R2", obs(0), ex(6, 2'b11));
        ld_n[0] = 1'b1;
        tick(0);
        chk(0, "R3", obs(0), ex(7, 2'b11));
        idle(0);

        // R11: same word shared, last writer per lane wins
        wr(1, 7, pat(7, 50), 2'b11);
        rd(0, 7, 2'b11);
        chk(0, "R11", obs(0), ex(7, 2'b11));
        rd(1, 7, 2'b11);
        chk(1, "R11", obs(1), ex(7, 2'b11));
        wr(0, 8, pat(8, 60), 2'b11);
        wr(1, 8, pat(8, 61), 2'b01);
        rd(0, 8, 2'b11);
        chk(0, "R11", obs(0), ex(8, 2'b11));
        wr(0, 8, pat(8, 62), 2'b10);
        rd(1, 8, 2'b11);
        chk(1, "R11", obs(1), ex(8, 2'b11));
        wr(1, 8, pat(8, 63), 2'b10);
        rd(0, 8, 2'b11);
        chk(0, "R11", obs(0), ex(8, 2'b11));

        // R12: reset returns the address to 0 (read with counter holding)
        rd(0, 11, 2'b11);
        rst_n = 1'b0;
        #20 rst_n = 1'b1;
        ch[0] = 1'b1; cln[0] = 1'b0; hb[0] = 1'b0; lb[0] = 1'b0;
        tick(0);
        chk(0, "R12", obs(0), ex(0, 2'b11));
        idle(0);

        report();
    end
endmodule